// File: doc/BRIEF.md
# Decade-Step Sample Clock Generator

This block produces the conversion-start strobe for a bank of simultaneously sampled converters. A 5-bit rate code picks one of seventeen fixed sample rates from 1 Hz to 160 kHz. The rates step in a 1-2-5 pattern through each decade. The block can instead follow an external sample clock pin, with each rising edge of that pin producing one strobe. Nothing is produced unless the arm input is high. Each strobe is a single system-clock cycle wide and goes to every channel at the same time.

Internal rates come from a terminal-count divider. Its period is taken from a computed table indexed by the rate code and by the system-clock speed select: the fast clock by default is 32 MHz and the slow one 8 MHz. The top rate can only be reached on the fast clock. Illegal codes fall back to 100 kHz. The external pin passes through a two-flop synchroniser and a rising-edge detector before it is used.

Top module: `decade_sample_clock`

## Requirements
- R1: After reset, and for as long as `arm` is low, every bit of `conv_start` is 0.
- R2: Rate code c (0..15) selects a rate of m x 10^d Hz, where d = c/3 and m is 1, 2 or 5 for c%3 = 0, 1 or 2. The strobe period in system clocks is max(2, floor(F / rate)), where F is FAST_CLK_HZ when `fast_clk_sel` = 1 and SLOW_CLK_HZ when it is 0.
- R3: Code 16 selects 160 kHz when `fast_clk_sel` = 1. When `fast_clk_sel` = 0, code 16 gives the 100 kHz period instead.
- R4: Codes 17 to 31 give the 100 kHz period on either clock.
- R5: Every strobe is exactly one cycle wide, and all N_CH bits of `conv_start` are equal at all times.
- R6: The divider is held cleared while disarmed. The first strobe after `arm` rises is high in the cycle that follows rising edge P-1, where the first rising edge that samples `arm` high counts as edge 0 and P is the period from R2. Later strobes follow every P cycles.
- R7: When `rate_code` or `fast_clk_sel` changes while armed, the count restarts. The next strobe is high in the cycle that follows edge P, where edge 0 is the first rising edge that samples the new value and P is the new period.
- R8: With `ext_clk_en` = 1, each rising edge of `ext_clk_pin` gives one strobe. The strobe is high in the cycle that follows the third rising clock edge after the pin change. The internal divider produces no strobes in this mode.
- R9: Rising edges of `ext_clk_pin` that arrive while `arm` is low produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_clk_sel | input | 1 | 1: system clock runs at FAST_CLK_HZ; 0: it runs at SLOW_CLK_HZ |
| rate_code | input | 5 | Internal sample rate select |
| ext_clk_en | input | 1 | 1: use the external pin in place of the internal rate |
| arm | input | 1 | Enables strobe generation |
| ext_clk_pin | input | 1 | Asynchronous external sample clock |
| conv_start | output | N_CH | Conversion-start strobe, one identical bit per channel |

## Verification
The bench builds the block with FAST_CLK_HZ = 320000, SLOW_CLK_HZ = 80000 and N_CH = 4. These values scale the rate table down so that the periods of most codes are a few to a few thousand cycles, and can be measured exactly within the cycle budget. At these values the 160 kHz and 100 kHz entries land on the two-cycle floor and on periods of 2 or 3 cycles. This puts the fallback rules and the minimum-period clamp in reach of the bench. The slowest fast-clock rate the bench measures is 20 Hz, at 16000 cycles.

// File: rtl/sclk_pkg.sv
// Package for the decade-step sample clock generator.
// Holds the rate-code decode and the period arithmetic shared by the lookup.
// Assumes the fast system clock frequency is not below the slow one.
package sclk_pkg;

    localparam int CODE_W   = 5;
    localparam int TOP_CODE = 16;
    localparam int FALLBACK = 15;

    // Map a raw code onto the code whose rate is actually used.
    function automatic int eff_code(input int code, input bit fast);
        if (code > TOP_CODE || (code == TOP_CODE && !fast))
            return FALLBACK;
        return code;
    endfunction

    // Rate in Hz for an effective code: 1-2-5 steps per decade, 160 kHz at the top.
    function automatic int rate_hz(input int code);
        int mant;
        int r;
        if (code == TOP_CODE)
            return 160000;
        mant = (code % 3 == 0) ? 1 : ((code % 3 == 1) ? 2 : 5);
        r = mant;
        for (int i = 0; i < code / 3; i++)
            r = r * 10;
        return r;
    endfunction

    // Divider period in system clocks, never below two.
    function automatic int period_clks(input int code, input bit fast,
                                       input int fast_hz, input int slow_hz);
        int p;
        p = (fast ? fast_hz : slow_hz) / rate_hz(eff_code(code, fast));
        return (p < 2) ? 2 : p;
    endfunction

endpackage

// File: rtl/sclk_rate_lut.sv
// Rate lookup: returns the divider period for a rate code and clock select.
// The table is built at elaboration from the package arithmetic (2 x 32 entries).
// Assumes CNT_W can hold the slowest period on the fast clock.
module sclk_rate_lut
    import sclk_pkg::*;
#(
    parameter int FAST_CLK_HZ = 32_000_000,
    parameter int SLOW_CLK_HZ = 8_000_000,
    parameter int CNT_W       = 25
) (
    input  logic              fast_sel,
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  period
);
    localparam int N_CODES = 1 << CODE_W;

    logic [CNT_W-1:0] tbl [2*N_CODES];

    // Fill one table entry per (clock select, code) pair.
    for (genvar s = 0; s < 2; s++) begin : g_speed
        for (genvar c = 0; c < N_CODES; c++) begin : g_code
            assign tbl[s*N_CODES + c] =
                CNT_W'(period_clks(c, s[0], FAST_CLK_HZ, SLOW_CLK_HZ));
        end
    end

    // Pick the entry for the current inputs.
    assign period = tbl[{fast_sel, code}];

endmodule

// File: rtl/sclk_divider.sv
// Terminal-count divider producing a one-cycle tick every `period` clocks.
// It is held at zero while disabled and restarts whenever the selection key changes.
// Assumes period >= 2.
module sclk_divider #(
    parameter int CNT_W = 25,
    parameter int KEY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [KEY_W-1:0] key,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic [KEY_W-1:0] key_q;
    logic             restart;

    assign restart = (key != key_q);
    assign tick    = en && !restart && (cnt == period - CNT_W'(1));

    // Remember the last selection so that a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) key_q <= '0;
        else        key_q <= key;
    end

    // Count up to the terminal value, clearing on disable, restart or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart || tick) cnt <= '0;
        else                                 cnt <= cnt + CNT_W'(1);
    end

    // R6: a disabled divider is empty on the following cycle.
    a_r6_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '0);

    // R2: with a stable selection the count never reaches the period.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (key == key_q) |-> cnt < period);

endmodule

// File: rtl/sclk_ext_edge.sv
// External clock capture: a two-flop synchroniser followed by a rising-edge detector.
// Assumes the pin is asynchronous to clk and stays high or low for at least two clocks.
module sclk_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic s1, s2, s3;

    // Bring the pin into the clock domain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) {s1, s2, s3} <= 3'b000;
        else        {s1, s2, s3} <= {pin, s1, s2};
    end

    assign rise = s2 && !s3;

    // R8: an edge pulse never lasts two cycles.
    a_r8_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/decade_sample_clock.sv
// Decade-step sample clock generator (top).
// Drives a registered one-cycle conversion start to all channels. The start comes
// either from the internal rate divider or from the synchronised external clock edge,
// and only while armed.
// Assumes FAST_CLK_HZ >= SLOW_CLK_HZ.
module decade_sample_clock
    import sclk_pkg::*;
#(
    parameter int FAST_CLK_HZ = 32_000_000,
    parameter int SLOW_CLK_HZ = 8_000_000,
    parameter int N_CH        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_clk_sel,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              ext_clk_en,
    input  logic              arm,
    input  logic              ext_clk_pin,
    output logic [N_CH-1:0]   conv_start
);
    localparam int CNT_W = $clog2(FAST_CLK_HZ + 1);
    localparam int KEY_W = CODE_W + 1;

    logic [CNT_W-1:0] period;
    logic             int_tick;
    logic             ext_rise;
    logic             start_q;

    sclk_rate_lut #(
        .FAST_CLK_HZ(FAST_CLK_HZ),
        .SLOW_CLK_HZ(SLOW_CLK_HZ),
        .CNT_W      (CNT_W)
    ) u_lut (
        .fast_sel(fast_clk_sel),
        .code    (rate_code),
        .period  (period)
    );

    sclk_divider #(
        .CNT_W(CNT_W),
        .KEY_W(KEY_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (arm && !ext_clk_en),
        .key   ({fast_clk_sel, rate_code}),
        .period(period),
        .tick  (int_tick)
    );

    sclk_ext_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_clk_pin),
        .rise (ext_rise)
    );

    // Register the selected, armed strobe source.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= arm && (ext_clk_en ? ext_rise : int_tick);
    end

    // Fan the single strobe out to every channel.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_fanout
        assign conv_start[ch] = start_q;
    end

    // R9 / R1: a strobe is only issued if the unit was armed on the previous edge.
    a_r9_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> $past(arm));

    // R5: strobes are single-cycle.
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);

    // R8: in external mode a strobe follows a detected pin edge.
    a_r8_ext_source: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && $past(ext_clk_en)) |-> $past(ext_rise));

endmodule

// File: tb/decade_sample_clock_tb.sv
module decade_sample_clock_tb;
    localparam int FAST = 320_000;
    localparam int SLOW = 80_000;
    localparam int NCH  = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           fast_clk_sel;
    logic [4:0]     rate_code;
    logic           ext_clk_en;
    logic           arm;
    logic           ext_clk_pin;
    logic [NCH-1:0] conv_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    decade_sample_clock #(
        .FAST_CLK_HZ(FAST), .SLOW_CLK_HZ(SLOW), .N_CH(NCH)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .fast_clk_sel(fast_clk_sel),
        .rate_code(rate_code), .ext_clk_en(ext_clk_en), .arm(arm),
        .ext_clk_pin(ext_clk_pin), .conv_start(conv_start)
    );

    // Expected rate from the requirement table, fallbacks included.
    function automatic int ref_rate(input int code, input bit fast);
        if (code > 16 || (code == 16 && !fast)) return 100000;
        case (code)
            0: return 1;       1: return 2;       2: return 5;
            3: return 10;      4: return 20;      5: return 50;
            6: return 100;     7: return 200;     8: return 500;
            9: return 1000;    10: return 2000;   11: return 5000;
            12: return 10000;  13: return 20000;  14: return 50000;
            15: return 100000; default: return 160000;
        endcase
    endfunction

    function automatic int ref_period(input int code, input bit fast);
        int p;
        p = (fast ? FAST : SLOW) / ref_rate(code, fast);
        return (p < 2) ? 2 : p;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Count negedges until a strobe is seen (or max is passed); checks the fan-out.
    task automatic wait_strobe(input int max, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (conv_start[0] !== 1'b1 && n <= max);
        if (conv_start[0] === 1'b1)
            check(conv_start == {NCH{1'b1}}, "R5 fanout", int'(conv_start), (1 << NCH) - 1);
    endtask

    // Count strobes over a window of cycles.
    task automatic count_strobes(input int cycles, output int k);
        k = 0;
        for (int i = 0; i < cycles; i++) begin
            step();
            if (conv_start !== '0) k++;
        end
    endtask

    // Disarm, select a rate, arm, and check the first strobe and the next interval.
    task automatic arm_and_measure(input int code, input bit fast, input bit twice, input string req);
        int p, n;
        arm = 0; rate_code = 5'(code); fast_clk_sel = fast;
        step(); step();
        arm = 1;
        p = ref_period(code, fast);
        wait_strobe(p + 2, n);
        check(n == p, {req, " first strobe after arm"}, n, p);
        step();
        check(conv_start == '0, "R5 width", int'(conv_start), 0);
        if (twice) begin
            wait_strobe(p + 2, n);
            check(n == p - 1, {req, " steady period"}, n + 1, p);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n, k, p;
        void'($urandom(32'd1234));
        rst_n = 0; fast_clk_sel = 1; rate_code = 16; ext_clk_en = 0; arm = 0; ext_clk_pin = 0;
        repeat (3) step();
        check(conv_start == '0, "R1 reset", int'(conv_start), 0);
        rst_n = 1;

        // R1: no strobe while disarmed, even at the fastest code.
        count_strobes(50, k);
        check(k == 0, "R1 disarmed silent", k, 0);

        // R2: table entries on both clocks.
        arm_and_measure(16, 1, 1, "R3 code16 fast");
        arm_and_measure(15, 1, 1, "R2 code15 fast");
        arm_and_measure(12, 1, 1, "R2 code12 fast");
        arm_and_measure(9, 1, 1, "R2 code9 fast");
        arm_and_measure(6, 1, 1, "R2 code6 fast");
        arm_and_measure(4, 1, 0, "R2 code4 fast");
        arm_and_measure(5, 0, 1, "R2 code5 slow");
        arm_and_measure(9, 0, 1, "R2 code9 slow");
        // R3: code 16 on the slow clock falls back.
        arm_and_measure(16, 0, 1, "R3 code16 slow");
        // R4: illegal codes fall back on both clocks.
        arm_and_measure(20, 1, 1, "R4 code20 fast");
        arm_and_measure(31, 0, 1, "R4 code31 slow");

        // R6: the first-strobe timing with a longer period.
        arm_and_measure(10, 1, 0, "R6 code10 fast");

        // R7: a rate change while armed restarts the count.
        arm_and_measure(12, 1, 0, "R7 setup");
        rate_code = 11;
        p = ref_period(11, 1);
        wait_strobe(p + 3, n);
        check(n == p + 1, "R7 restart on code change", n, p + 1);
        fast_clk_sel = 0;
        p = ref_period(11, 0);
        wait_strobe(p + 3, n);
        check(n == p + 1, "R7 restart on clock select change", n, p + 1);

        // R8: external mode, internal divider silent.
        arm = 1; rate_code = 16; fast_clk_sel = 1; ext_clk_en = 1; ext_clk_pin = 0;
        count_strobes(30, k);
        check(k == 0, "R8 internal silent", k, 0);
        for (int e = 0; e < 4; e++) begin
            ext_clk_pin = 1;
            wait_strobe(6, n);
            check(n == 3, "R8 ext edge latency", n, 3);
            count_strobes(2 + e, k);
            ext_clk_pin = 0;
            count_strobes(4, k);
            check(k == 0, "R8 one strobe per edge", k, 0);
        end

        // R9: edges while disarmed are ignored.
        arm = 0;
        for (int e = 0; e < 3; e++) begin
            ext_clk_pin = 1; count_strobes(5, k);
            check(k == 0, "R9 disarmed rise", k, 0);
            ext_clk_pin = 0; count_strobes(5, k);
        end
        ext_clk_en = 0;

        // Random rates and clock selects.
        for (int i = 0; i < 12; i++) begin
            int c;
            bit f;
            c = 6 + int'($urandom_range(0, 25));
            f = 1'($urandom_range(0, 1));
            arm_and_measure(c, f, 1, $sformatf("R2 random code%0d sel%0d", c, f));
        end

        arm = 0;
        count_strobes(10, k);
        check(k == 0, "R1 silent after disarm", k, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule